// File: doc/BRIEF.md
# Vector-Prefix Feature Legality Trap Unit

This block sits in the decode stage of a scalar-only core. The core accepts a vector-style instruction prefix but implements only some of the features that the prefix can ask for. For every issued instruction the unit decides between two outcomes. It either lets the instruction execute in hardware, or it raises an illegal-instruction trap so that software can emulate the missing feature. The decision does not rest on the opcode alone. It also depends on the current contents of the vector-state register and on the fields of the decoded prefix.

The unit owns the vector-state register. This register holds the vector length and the mode bits. A build-time mask lists the features the hardware supports. The unit gathers the feature request into one word: the vector-state fields plus the prefix's element-width override and predicate request. If any bit of that word falls outside the mask, the instruction traps. Three further cases also trap:

- a prefixed opcode that the core does not implement;
- any access to a special register in the reserved window;
- the set-vector-length instruction, when the build leaves it to software.

When an instruction traps, the unit gives it no side effects. It sends a one-cycle trap request, together with the fixed vector and the faulting address. It then stalls issue until the trap is acknowledged.

Top module: `vpfx_legality_unit`

## Requirements
- R1: After reset, `trap_req` and `exec_go` are 0 and `iss_ready` is 1. `vstate` is all zero, which encodes vector length 1 with no mode bits set.
- R2: An instruction is accepted in a cycle where `iss_valid` and `iss_ready` are both 1. If it is legal, `exec_go` is 1 for exactly the next cycle and `trap_req` stays 0.
- R3: A prefixed instruction traps when the stored vector length is greater than 1, that is, when `vstate[7:0]` (vector length minus 1) is nonzero.
- R4: A prefixed instruction traps when it requests an element-width override (`iss_ew_ovr` nonzero). A prefixed instruction that only requests predication (`iss_pred_en`=1) executes.
- R5: A prefixed instruction traps when any mode bit `vstate[11:8]` is set, because none of them is in the default support mask.
- R6: A prefixed instruction whose opcode is not implemented (`iss_op_known`=0) traps. An unprefixed instruction with `iss_op_known`=0 executes.
- R7: An access to a special register numbered from 704 to 719 inclusive traps, whether or not the instruction is prefixed. Accesses to numbers outside that window execute.
- R8: With a trap, `trap_vec` reads 0x700. `trap_pc` holds the faulting instruction's `iss_pc` from the pulse cycle until the trap is acknowledged.
- R9: `trap_req` is high for exactly one cycle. `iss_ready` is 0 from that cycle on, and returns to 1 in the cycle after `trap_ack` is sampled high.
- R10: With `SETVL_IMPL`=1, a legal set-vector-length instruction writes `vstate[7:0]` = `iss_setvl_len`-1 (a length of 0 is treated as 1) and writes `vstate[11:8]` = `iss_setvl_mode`. The new value is visible in the cycle after acceptance.
- R11: An instruction that traps leaves `vstate` unchanged and never raises `exec_go`.
- R12: With `SETVL_IMPL`=0, every set-vector-length instruction traps and `vstate` keeps its value.
- R13: An unprefixed instruction that is neither a set-vector-length nor a reserved register access executes, whatever `vstate` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_ready | output | 1 | Unit can accept an instruction (low while a trap is unacknowledged) |
| iss_pc | input | AW | Address of the offered instruction |
| iss_prefixed | input | 1 | Instruction carries the vector prefix |
| iss_op_known | input | 1 | Opcode is implemented in hardware |
| iss_ew_ovr | input | 2 | Element-width override request from the prefix (0 = none) |
| iss_pred_en | input | 1 | Predicate (source mask) request from the prefix |
| iss_setvl | input | 1 | Instruction is set-vector-length |
| iss_setvl_len | input | 8 | Requested vector length |
| iss_setvl_mode | input | 4 | Mode bits written by set-vector-length |
| iss_spr_acc | input | 1 | Instruction reads or writes a special register |
| iss_spr_num | input | SPRW | Special register number |
| trap_ack | input | 1 | Trap handler has taken the trap |
| trap_req | output | 1 | One-cycle illegal-instruction trap request |
| trap_vec | output | AW | Trap vector address (0x700) |
| trap_pc | output | AW | Address of the faulting instruction |
| exec_go | output | 1 | One-cycle go-ahead and writeback enable |
| vstate | output | 12 | Vector-state register: mode bits [11:8], vector length minus 1 [7:0] |

## Verification
The bound assertions check the following on every cycle:

- The trap is a single-cycle pulse, and issue stays blocked until the acknowledge.
- `trap_pc` does not move while issue is blocked.
- A trap and a go-ahead never occur together, and a trap leaves the vector state unchanged.
- Every go-ahead follows an accepted instruction.
- An unimplemented prefixed opcode, a reserved register access, and a plain unprefixed instruction each lead to the expected outcome one cycle later.

Only the bench scenarios can show the checks that depend on history:

- the feature-mask decisions for vector lengths and mode bits that earlier set-vector-length instructions stored;
- the length-minus-one encoding, including the zero-length case;
- the difference between the two set-vector-length build options.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
    parameter int VLW   = 8;
    parameter int MODEW = 4;
    parameter int EWW   = 2;
    parameter int REQW  = MODEW + 1 + EWW + VLW;
    parameter int SW    = MODEW + VLW;

    typedef struct packed {
        logic [MODEW-1:0] mode;
        logic [VLW-1:0]   vlm1;
    } vstate_t;

    typedef struct packed {
        logic [MODEW-1:0] mode;
        logic             pred;
        logic [EWW-1:0]   ew;
        logic [VLW-1:0]   vlm1;
    } feat_req_t;

    parameter logic [REQW-1:0] PRED_ONLY_MASK = REQW'(1) << (VLW + EWW);
endpackage

// File: rtl/vpfx_feat_check.sv
module vpfx_feat_check
    import vpfx_pkg::*;
#(
    parameter logic [REQW-1:0] MASK = PRED_ONLY_MASK
) (
    input  feat_req_t req,
    output logic      unsupp
);
    always_comb begin
        unsupp = |(req & ~MASK);
    end
endmodule

// File: rtl/vpfx_spr_window.sv
module vpfx_spr_window #(
    parameter int              SPRW = 10,
    parameter logic [SPRW-1:0] LO   = SPRW'(704),
    parameter logic [SPRW-1:0] HI   = SPRW'(719)
) (
    input  logic            acc,
    input  logic [SPRW-1:0] num,
    output logic            hit
);
    always_comb begin
        hit = acc && (num >= LO) && (num <= HI);
    end
endmodule

// File: rtl/vpfx_vl_encode.sv
module vpfx_vl_encode #(
    parameter int VLW = 8
) (
    input  logic [VLW-1:0] len,
    output logic [VLW-1:0] vlm1
);
    always_comb begin
        vlm1 = (len == '0) ? '0 : len - VLW'(1);
    end
endmodule

// File: rtl/vpfx_legality_unit.sv
module vpfx_legality_unit
    import vpfx_pkg::*;
#(
    parameter int              AW         = 32,
    parameter int              SPRW       = 10,
    parameter logic [REQW-1:0] SUPP_MASK  = PRED_ONLY_MASK,
    parameter bit              SETVL_IMPL = 1'b1,
    parameter logic [SPRW-1:0] RSV_LO     = SPRW'(704),
    parameter logic [SPRW-1:0] RSV_HI     = SPRW'(719),
    parameter logic [AW-1:0]   TRAP_VEC   = AW'(32'h700)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    output logic             iss_ready,
    input  logic [AW-1:0]    iss_pc,
    input  logic             iss_prefixed,
    input  logic             iss_op_known,
    input  logic [EWW-1:0]   iss_ew_ovr,
    input  logic             iss_pred_en,
    input  logic             iss_setvl,
    input  logic [VLW-1:0]   iss_setvl_len,
    input  logic [MODEW-1:0] iss_setvl_mode,
    input  logic             iss_spr_acc,
    input  logic [SPRW-1:0]  iss_spr_num,
    input  logic             trap_ack,
    output logic             trap_req,
    output logic [AW-1:0]    trap_vec,
    output logic [AW-1:0]    trap_pc,
    output logic             exec_go,
    output logic [SW-1:0]    vstate
);
    typedef struct packed {
        logic          trap;
        logic          go;
        logic          pend;
        logic [AW-1:0] pc;
        vstate_t       vs;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    feat_req_t req_w;
    logic      feat_bad_w;
    logic      spr_bad_w;
    logic      pfx_bad_w;
    logic      setvl_bad_w;
    logic      illegal_w;
    logic      accept_w;
    logic [VLW-1:0] new_vlm1_w;

    always_comb begin
        req_w.mode = ctl_q.vs.mode;
        req_w.pred = iss_pred_en;
        req_w.ew   = iss_ew_ovr;
        req_w.vlm1 = ctl_q.vs.vlm1;
    end

    vpfx_feat_check #(.MASK(SUPP_MASK)) u_feat (
        .req    (req_w),
        .unsupp (feat_bad_w)
    );

    vpfx_spr_window #(.SPRW(SPRW), .LO(RSV_LO), .HI(RSV_HI)) u_spr (
        .acc (iss_spr_acc),
        .num (iss_spr_num),
        .hit (spr_bad_w)
    );

    vpfx_vl_encode #(.VLW(VLW)) u_vlenc (
        .len  (iss_setvl_len),
        .vlm1 (new_vlm1_w)
    );

    always_comb begin
        pfx_bad_w   = iss_prefixed && (!iss_op_known || feat_bad_w);
        setvl_bad_w = iss_setvl && !SETVL_IMPL;
        illegal_w   = pfx_bad_w || spr_bad_w || setvl_bad_w;
        accept_w    = iss_valid && !ctl_q.pend;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.trap = 1'b0;
        ctl_d.go   = 1'b0;
        if (accept_w) begin
            ctl_d.trap = illegal_w;
            ctl_d.go   = !illegal_w;
            ctl_d.pend = illegal_w;
            ctl_d.pc   = iss_pc;
            if (iss_setvl && !illegal_w) begin
                ctl_d.vs.vlm1 = new_vlm1_w;
                ctl_d.vs.mode = iss_setvl_mode;
            end
        end else if (ctl_q.pend && trap_ack) begin
            ctl_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign iss_ready = !ctl_q.pend;
    assign trap_req  = ctl_q.trap;
    assign trap_vec  = TRAP_VEC;
    assign trap_pc   = ctl_q.pc;
    assign exec_go   = ctl_q.go;
    assign vstate    = ctl_q.vs;
endmodule

// File: rtl/vpfx_legality_sva.sv
module vpfx_legality_sva
    import vpfx_pkg::*;
#(
    parameter int              AW     = 32,
    parameter int              SPRW   = 10,
    parameter logic [SPRW-1:0] RSV_LO = SPRW'(704),
    parameter logic [SPRW-1:0] RSV_HI = SPRW'(719)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iss_valid,
    input logic            iss_ready,
    input logic            iss_prefixed,
    input logic            iss_op_known,
    input logic            iss_setvl,
    input logic            iss_spr_acc,
    input logic [SPRW-1:0] iss_spr_num,
    input logic            trap_ack,
    input logic            trap_req,
    input logic [AW-1:0]   trap_pc,
    input logic            exec_go,
    input logic [SW-1:0]   vstate
);
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !iss_ready);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_ready && trap_ack) |=> iss_ready);

    a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_ready && $past(!iss_ready)) |-> $stable(trap_pc));

    a_r11_no_state_change: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $stable(vstate));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && exec_go));

    a_r2_go_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |-> $past(iss_valid && iss_ready));

    a_r6_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_prefixed && !iss_op_known) |=> trap_req);

    a_r7_reserved_spr: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_spr_acc &&
         (iss_spr_num >= RSV_LO) && (iss_spr_num <= RSV_HI)) |=> trap_req);

    a_r13_plain_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !iss_prefixed && !iss_setvl && !iss_spr_acc) |=> exec_go);
endmodule

bind vpfx_legality_unit vpfx_legality_sva #(
    .AW(AW), .SPRW(SPRW), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)
) u_sva (.*);

// File: tb/vpfx_legality_unit_bench.sv
module vpfx_legality_unit_bench;
    import vpfx_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        iss_valid = 0, iss_prefixed = 0, iss_op_known = 1, iss_pred_en = 0;
    logic        iss_setvl = 0, iss_spr_acc = 0, trap_ack = 0;
    logic [31:0] iss_pc = 0;
    logic [1:0]  iss_ew_ovr = 0;
    logic [7:0]  iss_setvl_len = 0;
    logic [3:0]  iss_setvl_mode = 0;
    logic [9:0]  iss_spr_num = 0;

    logic        a_ready, a_trap, a_go, b_ready, b_trap, b_go;
    logic [31:0] a_vec, a_pc, b_vec, b_pc;
    logic [11:0] a_vs, b_vs;

    vpfx_legality_unit u_vpfx_legality_unit (
        .clk, .rst_n, .iss_valid, .iss_ready(a_ready), .iss_pc, .iss_prefixed,
        .iss_op_known, .iss_ew_ovr, .iss_pred_en, .iss_setvl, .iss_setvl_len,
        .iss_setvl_mode, .iss_spr_acc, .iss_spr_num, .trap_ack,
        .trap_req(a_trap), .trap_vec(a_vec), .trap_pc(a_pc), .exec_go(a_go), .vstate(a_vs));

    vpfx_legality_unit #(.SETVL_IMPL(1'b0)) u_vpfx_legality_unit_swvl (
        .clk, .rst_n, .iss_valid, .iss_ready(b_ready), .iss_pc, .iss_prefixed,
        .iss_op_known, .iss_ew_ovr, .iss_pred_en, .iss_setvl, .iss_setvl_len,
        .iss_setvl_mode, .iss_spr_acc, .iss_spr_num, .trap_ack,
        .trap_req(b_trap), .trap_vec(b_vec), .trap_pc(b_pc), .exec_go(b_go), .vstate(b_vs));

    // Behavioural reference model, index 0 = hardware set-length, 1 = trapping set-length
    bit          m_trap[2], m_go[2], m_pend[2];
    logic [31:0] m_pc[2];
    int          m_vl[2];
    logic [3:0]  m_mode[2];
    int          n_cmp = 0, n_bad = 0, cyc = 0;
    string       cur_tag = "R1";

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_trap[k] = 0; m_go[k] = 0; m_pend[k] = 0; m_pc[k] = 0; m_vl[k] = 1; m_mode[k] = 0;
        end
    end

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_trap[k] = 0; m_go[k] = 0; m_pend[k] = 0; m_pc[k] = 0; m_vl[k] = 1; m_mode[k] = 0;
            end else if (iss_valid && !m_pend[k]) begin
                bit bad;
                bad = 0;
                if (iss_prefixed && (!iss_op_known || m_vl[k] > 1 || iss_ew_ovr != 0 || m_mode[k] != 0))
                    bad = 1;
                if (iss_spr_acc && iss_spr_num >= 704 && iss_spr_num <= 719) bad = 1;
                if (iss_setvl && k == 1) bad = 1;
                m_trap[k] = bad; m_go[k] = !bad; m_pend[k] = bad; m_pc[k] = iss_pc;
                if (iss_setvl && !bad) begin
                    m_vl[k]   = (iss_setvl_len == 0) ? 1 : int'(iss_setvl_len);
                    m_mode[k] = iss_setvl_mode;
                end
            end else begin
                m_trap[k] = 0; m_go[k] = 0;
                if (m_pend[k] && trap_ack) m_pend[k] = 0;
            end
        end
    end

    task automatic cmp(input int k, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s inst%0d %s: actual=%0h expected=%0h (t=%0t)", cur_tag, k, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cmp(0, "trap_req R9", 64'(a_trap), 64'(m_trap[0]));
        cmp(0, "exec_go R2", 64'(a_go), 64'(m_go[0]));
        cmp(0, "iss_ready R9", 64'(a_ready), 64'(!m_pend[0]));
        cmp(0, "trap_pc R8", 64'(a_pc), 64'(m_pc[0]));
        cmp(0, "trap_vec R8", 64'(a_vec), 64'h700);
        cmp(0, "vstate R10", 64'(a_vs), 64'({m_mode[0], 8'(m_vl[0] - 1)}));
        cmp(1, "trap_req R12", 64'(b_trap), 64'(m_trap[1]));
        cmp(1, "exec_go R2", 64'(b_go), 64'(m_go[1]));
        cmp(1, "iss_ready R9", 64'(b_ready), 64'(!m_pend[1]));
        cmp(1, "trap_pc R8", 64'(b_pc), 64'(m_pc[1]));
        cmp(1, "vstate R12", 64'(b_vs), 64'({m_mode[1], 8'(m_vl[1] - 1)}));
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R9 watchdog: cycles=%0d expected<=150000", cyc);
            summary();
        end
    end

    // Drive one instruction at a negedge, then acknowledge any trap.
    task automatic issue(input string tag, input logic pfx, input logic known, input logic [1:0] ew,
                         input logic pred, input logic sv, input logic [7:0] len, input logic [3:0] mode,
                         input logic spr, input logic [9:0] num, input logic [31:0] pc);
        cur_tag = tag;
        iss_valid = 1; iss_prefixed = pfx; iss_op_known = known; iss_ew_ovr = ew; iss_pred_en = pred;
        iss_setvl = sv; iss_setvl_len = len; iss_setvl_mode = mode; iss_spr_acc = spr;
        iss_spr_num = num; iss_pc = pc;
        @(negedge clk);
        iss_valid = 0; trap_ack = 1;
        @(negedge clk);
        trap_ack = 0;
    endtask

    initial begin
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        issue("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0, 32'h100);
        issue("R4", 1, 1, 0, 1, 0, 0, 0, 0, 0, 32'h104);
        issue("R4", 1, 1, 2'b01, 0, 0, 0, 0, 0, 0, 32'h108);
        issue("R4", 1, 1, 2'b11, 1, 0, 0, 0, 0, 0, 32'h10c);
        issue("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h110);
        issue("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h114);
        issue("R7", 0, 1, 0, 0, 0, 0, 0, 1, 10'd704, 32'h118);
        issue("R7", 1, 1, 0, 0, 0, 0, 0, 1, 10'd719, 32'h11c);
        issue("R7", 0, 1, 0, 0, 0, 0, 0, 1, 10'd703, 32'h120);
        issue("R7", 0, 1, 0, 0, 0, 0, 0, 1, 10'd720, 32'h124);
        issue("R10", 0, 1, 0, 0, 1, 8'd4, 0, 0, 0, 32'h128);
        issue("R3", 1, 1, 0, 0, 0, 0, 0, 0, 0, 32'h12c);
        issue("R13", 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h130);
        issue("R10", 0, 1, 0, 0, 1, 8'd0, 0, 0, 0, 32'h134);
        issue("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0, 32'h138);
        issue("R5", 0, 1, 0, 0, 1, 8'd1, 4'b0010, 0, 0, 32'h13c);
        issue("R5", 1, 1, 0, 1, 0, 0, 0, 0, 0, 32'h140);
        issue("R13", 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h144);
        issue("R11", 1, 1, 2'b10, 0, 1, 8'd5, 0, 0, 0, 32'h148);
        issue("R12", 0, 1, 0, 0, 1, 8'd1, 0, 0, 0, 32'h14c);
        issue("R11", 1, 1, 2'b01, 0, 1, 8'd7, 4'hf, 0, 0, 32'h150);
        // R8 / R9: trap then hold issue without acknowledge
        cur_tag = "R8";
        iss_valid = 1; iss_prefixed = 1; iss_op_known = 0; iss_ew_ovr = 0; iss_pred_en = 0;
        iss_setvl = 0; iss_spr_acc = 0; iss_pc = 32'h200;
        @(negedge clk);
        iss_pc = 32'h204; iss_prefixed = 0; iss_op_known = 1;
        repeat (4) @(negedge clk);
        cur_tag = "R9";
        trap_ack = 1;
        @(negedge clk);
        trap_ack = 0;
        @(negedge clk);
        iss_valid = 0;
        @(negedge clk);
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [9:0] num;
            num = 10'd698 + 10'($urandom_range(0, 27));
            issue("R3/R4/R5/R6/R7/R10/R11/R12/R13",
                  1'($urandom_range(0, 1)), ($urandom_range(0, 5) != 0),
                  ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
                  1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0),
                  8'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'h0,
                  ($urandom_range(0, 3) == 0), num, 32'h1000 + 32'(i * 4));
        end
        repeat (2) @(negedge clk);
        summary();
    end
endmodule